// File: doc/BRIEF.md
# Clock Monitor with Safe-Clock Failover

This block supervises a main oscillator clock and keeps a usable system clock present at all times. It runs on a free-running fast reference clock. On that clock it samples the main oscillator and a slow backup oscillator.

A spike filter accepts a main-clock level only once the level has lasted a minimum number of reference cycles. Narrower content, such as an oscillator running at a harmonic, is dropped. If every pulse is too narrow, no main clock reaches the output.

A loss detector compares filtered main-clock edges against backup-clock periods. A glitch-free route selector then moves the system clock to the backup clock, and moves it back once the main clock shows steady activity again.

Each failover sets a sticky status flag. The flag can raise an interrupt request, and that request also serves as a wake source for WAIT. In HALT the whole function is frozen and the request is withheld. A configuration input, captured during reset, turns the function off. When it is off, the raw main clock passes straight to the output.

Top module: `cm_clock_monitor`

## Requirements
- R1: When `opt_enable` is 0 during reset, `sys_clk_out` equals `main_clk_in` on every cycle after reset, and `status_flag` never sets.
- R2: Main-clock levels that last at least MIN_W reference cycles (default 2) pass to `sys_clk_out` at the main-clock rate. Levels shorter than MIN_W are removed.
- R3: If no accepted main-clock rising edge occurs between two consecutive backup-clock rising edges, `sys_clk_out` switches to the backup clock. This applies whether the main input is stuck low, stuck high, or carries only narrow spikes.
- R4: While on the backup clock, RECOV_EDGES (default 2) accepted main-clock rising edges return `sys_clk_out` to the main clock without any software action.
- R5: Every high or low level of `sys_clk_out` lasts at least 2 reference cycles, including the levels around a switch between sources. The old source is cut only when its level is low, or when the backup clock falls if the old main clock is stuck high. The new source is followed only after its level has been seen low.
- R6: Each switch to the backup clock sets `status_flag`, which then stays set until software pulses `flag_clr_we` high for one cycle.
- R7: `irq_req` is 1 exactly when `status_flag` is 1, `status_ie` is 1, `irq_mask` is 0 and `halt_mode` is 0. `status_ie` is loaded from `ie_wdata` when `ie_we` is high.
- R8: `wait_wake` is 1 when `irq_req` is 1 and `wait_mode` is 1. WAIT has no other effect on the block.
- R9: While `halt_mode` is 1, `status_flag` and `status_ie` ignore writes and failover events, `sys_clk_out` holds its level, and `irq_req` is 0.
- R10: After `halt_mode` returns to 0, the flag and enable values from before HALT are still in effect, and clock supervision resumes.
- R11: The reset state has `status_flag`, `status_ie`, `irq_req` and `sys_clk_out` at 0, with the main clock selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Fast reference clock that samples both oscillators |
| rst_n | input | 1 | Synchronous active-low reset |
| opt_enable | input | 1 | Function enable, captured while reset is active |
| main_clk_in | input | 1 | Main oscillator clock |
| safe_clk_in | input | 1 | Low-frequency backup oscillator clock |
| halt_mode | input | 1 | HALT low-power state: freezes the block |
| wait_mode | input | 1 | WAIT low-power state |
| irq_mask | input | 1 | Global interrupt mask, 1 = masked |
| ie_we | input | 1 | Write strobe for the interrupt-enable bit |
| ie_wdata | input | 1 | New interrupt-enable value |
| flag_clr_we | input | 1 | Write strobe that clears the failover flag |
| sys_clk_out | output | 1 | Supervised system clock |
| status_flag | output | 1 | Sticky failover flag |
| status_ie | output | 1 | Interrupt-enable bit |
| irq_req | output | 1 | Interrupt request |
| wait_wake | output | 1 | Request to leave WAIT |

## Verification
Four conditions are checked by assertions on every cycle:
- the flag stays set without a clear;
- the flag is frozen in HALT;
- the request stays quiet while masked or halted;
- each flag rise traces back to a detector failover event.

They also check the minimum width of every output clock level.

The bench's scenarios are the only place that shows:
- the output clock rate for each main half-period;
- failover for spikes, stuck-low and stuck-high inputs;
- the return after recovery;
- the state that carries through HALT;
- the passthrough when the function is disabled.

// File: rtl/cm_pkg.sv
// Shared types for the clock monitor.
package cm_pkg;
    // Route selector states: which source drives the output clock, or which
    // handover step is in progress.
    typedef enum logic [2:0] {
        RT_MAIN,
        RT_LEAVE_MAIN,
        RT_JOIN_SAFE,
        RT_SAFE,
        RT_LEAVE_SAFE,
        RT_JOIN_MAIN
    } route_e;
endpackage

// File: rtl/cm_spike_filter.sv
// Spike filter. Synchronizes the raw main clock into the reference domain
// and accepts a new level only after it has persisted for MIN_W reference
// cycles. Assumes the reference clock is several times faster than the main
// clock. When hold is high, all state is kept unchanged.
module cm_spike_filter #(
    parameter int MIN_W = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hold,
    input  logic raw,
    output logic lvl,
    output logic rise
);
    localparam int CW = $clog2(MIN_W + 1);

    logic          s1, s2;
    logic [CW-1:0] cnt;

    // Synchronize the input, count how long a differing level persists, and
    // accept the level once it has lasted MIN_W cycles.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1   <= 1'b0;
            s2   <= 1'b0;
            cnt  <= '0;
            lvl  <= 1'b0;
            rise <= 1'b0;
        end else if (!hold) begin
            s1   <= raw;
            s2   <= s1;
            rise <= 1'b0;
            if (s2 != lvl) begin
                if (cnt == CW'(MIN_W - 1)) begin
                    lvl  <= s2;
                    cnt  <= '0;
                    rise <= s2;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end else begin
                cnt <= '0;
            end
        end
    end
endmodule

// File: rtl/cm_loss_detector.sv
// Loss detector. Synchronizes the backup clock and declares the main clock
// lost when a whole backup period passes without an accepted main rising
// edge. The lost state clears after RECOV_EDGES accepted main edges that
// arrive without a silent backup period between them. Assumes the backup
// clock is much slower than the reference clock.
module cm_loss_detector #(
    parameter int RECOV_EDGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hold,
    input  logic safe_raw,
    input  logic main_rise,
    output logic safe_lvl,
    output logic safe_fall,
    output logic lost,
    output logic fail_evt
);
    localparam int RW = $clog2(RECOV_EDGES + 1);

    logic          s1, s2, s2_d;
    logic          armed, seen;
    logic [RW-1:0] rcnt;
    logic          safe_rise;

    assign safe_rise = s2 & ~s2_d;
    assign safe_fall = ~s2 & s2_d;
    assign safe_lvl  = s2;

    // Track main activity per backup period, declare loss, and count edges
    // toward recovery.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1       <= 1'b0;
            s2       <= 1'b0;
            s2_d     <= 1'b0;
            armed    <= 1'b0;
            seen     <= 1'b0;
            rcnt     <= '0;
            lost     <= 1'b0;
            fail_evt <= 1'b0;
        end else if (!hold) begin
            s1       <= safe_raw;
            s2       <= s1;
            s2_d     <= s2;
            fail_evt <= 1'b0;
            if (main_rise) seen <= 1'b1;
            if (safe_rise) begin
                armed <= 1'b1;
                seen  <= main_rise;
                if (!lost && armed && !seen && !main_rise) begin
                    lost     <= 1'b1;
                    fail_evt <= 1'b1;
                    rcnt     <= '0;
                end
                if (lost && !seen && !main_rise) rcnt <= '0;
            end
            if (lost && main_rise) begin
                if (rcnt == RW'(RECOV_EDGES - 1)) begin
                    lost <= 1'b0;
                    rcnt <= '0;
                end else begin
                    rcnt <= rcnt + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/cm_glitchless_mux.sv
// Glitch-free route selector, clocked by the reference clock. It cuts the
// old source only while that source is low, or when the backup clock falls
// if a dead main clock is stuck high. It then waits for the new source to
// be low before following it. The output is registered.
module cm_glitchless_mux
    import cm_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic hold,
    input  logic want_safe,
    input  logic main_lvl,
    input  logic safe_lvl,
    input  logic safe_fall,
    output logic clk_out
);
    route_e state, state_d;
    logic   out_d;

    // Next-state logic for the handover sequence.
    always_comb begin
        state_d = state;
        unique case (state)
            RT_MAIN:       if (want_safe) state_d = RT_LEAVE_MAIN;
            RT_LEAVE_MAIN: if (!main_lvl || safe_fall) state_d = RT_JOIN_SAFE;
            RT_JOIN_SAFE:  if (!safe_lvl) state_d = RT_SAFE;
            RT_SAFE:       if (!want_safe) state_d = RT_LEAVE_SAFE;
            RT_LEAVE_SAFE: if (want_safe) state_d = RT_SAFE;
                           else if (!safe_lvl) state_d = RT_JOIN_MAIN;
            RT_JOIN_MAIN:  if (want_safe) state_d = RT_JOIN_SAFE;
                           else if (!main_lvl) state_d = RT_MAIN;
            default:       state_d = RT_MAIN;
        endcase
    end

    // Output level for the state being entered; gated states drive low.
    always_comb begin
        unique case (state_d)
            RT_MAIN, RT_LEAVE_MAIN: out_d = main_lvl;
            RT_SAFE, RT_LEAVE_SAFE: out_d = safe_lvl;
            default:                out_d = 1'b0;
        endcase
    end

    // State and output registers, frozen while hold is high.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= RT_MAIN;
            clk_out <= 1'b0;
        end else if (!hold) begin
            state   <= state_d;
            clk_out <= out_d;
        end
    end
endmodule

// File: rtl/cm_clock_monitor.sv
// Clock monitor top. It captures the function enable during reset, chains
// the spike filter, loss detector and route selector, and keeps the failover
// flag, the interrupt enable and the request logic. HALT freezes every part
// of the block. With the function disabled, the raw main clock is passed
// through. Everything runs in the reference clock domain.
module cm_clock_monitor #(
    parameter int MIN_W       = 2,
    parameter int RECOV_EDGES = 2
) (
    input  logic ref_clk,
    input  logic rst_n,
    input  logic opt_enable,
    input  logic main_clk_in,
    input  logic safe_clk_in,
    input  logic halt_mode,
    input  logic wait_mode,
    input  logic irq_mask,
    input  logic ie_we,
    input  logic ie_wdata,
    input  logic flag_clr_we,
    output logic sys_clk_out,
    output logic status_flag,
    output logic status_ie,
    output logic irq_req,
    output logic wait_wake
);
    logic en_q, hold;
    logic main_lvl, main_rise;
    logic safe_lvl, safe_fall, lost, fail_evt;
    logic mux_clk;

    assign hold = ~en_q | halt_mode;

    // Capture the function enable while reset is active.
    always_ff @(posedge ref_clk) begin
        if (!rst_n) en_q <= opt_enable;
    end

    cm_spike_filter #(.MIN_W(MIN_W)) u_filt (
        .clk(ref_clk), .rst_n(rst_n), .hold(hold), .raw(main_clk_in),
        .lvl(main_lvl), .rise(main_rise)
    );

    cm_loss_detector #(.RECOV_EDGES(RECOV_EDGES)) u_det (
        .clk(ref_clk), .rst_n(rst_n), .hold(hold), .safe_raw(safe_clk_in),
        .main_rise(main_rise), .safe_lvl(safe_lvl), .safe_fall(safe_fall),
        .lost(lost), .fail_evt(fail_evt)
    );

    cm_glitchless_mux u_mux (
        .clk(ref_clk), .rst_n(rst_n), .hold(hold), .want_safe(lost),
        .main_lvl(main_lvl), .safe_lvl(safe_lvl), .safe_fall(safe_fall),
        .clk_out(mux_clk)
    );

    // Status and control bits; frozen in HALT, and a set wins over a clear.
    always_ff @(posedge ref_clk) begin
        if (!rst_n) begin
            status_flag <= 1'b0;
            status_ie   <= 1'b0;
        end else if (!halt_mode) begin
            if (ie_we) status_ie <= ie_wdata;
            if (fail_evt && en_q) status_flag <= 1'b1;
            else if (flag_clr_we) status_flag <= 1'b0;
        end
    end

    assign sys_clk_out = en_q ? mux_clk : main_clk_in;
    assign irq_req     = status_flag & status_ie & ~irq_mask & ~halt_mode;
    assign wait_wake   = irq_req & wait_mode;
endmodule

// File: rtl/cm_clock_monitor_chk.sv
// Assertion checker for the clock monitor, bound to the top module. It
// watches ports and the failover event between the detector and the status
// logic.
module cm_clock_monitor_chk #(
    parameter int MIN_W = 2
) (
    input logic ref_clk,
    input logic rst_n,
    input logic en_q,
    input logic halt_mode,
    input logic irq_mask,
    input logic flag_clr_we,
    input logic fail_evt,
    input logic status_flag,
    input logic status_ie,
    input logic irq_req,
    input logic sys_clk_out
);
    localparam int MINP = (MIN_W < 2) ? MIN_W : 2;

    logic       prev_out, chg_seen;
    logic [7:0] run;

    // Measure how long each output level lasts.
    always_ff @(posedge ref_clk) begin
        if (!rst_n) begin
            prev_out <= 1'b0;
            chg_seen <= 1'b0;
            run      <= 8'd0;
        end else begin
            prev_out <= sys_clk_out;
            if (sys_clk_out != prev_out) begin
                chg_seen <= 1'b1;
                run      <= 8'd1;
            end else if (run != 8'hFF) begin
                run <= run + 8'd1;
            end
        end
    end

    // R5
    min_level_width_chk: assert property (@(posedge ref_clk) disable iff (!rst_n)
        (en_q && chg_seen && sys_clk_out != prev_out) |-> (run >= 8'(MINP)));

    // R6
    flag_sticky_chk: assert property (@(posedge ref_clk) disable iff (!rst_n)
        (status_flag && !flag_clr_we) |=> status_flag);

    // R6
    flag_from_event_chk: assert property (@(posedge ref_clk) disable iff (!rst_n)
        $rose(status_flag) |-> $past(fail_evt));

    // R7
    mask_quiet_chk: assert property (@(posedge ref_clk) disable iff (!rst_n)
        irq_mask |-> !irq_req);

    // R9
    halt_quiet_chk: assert property (@(posedge ref_clk) disable iff (!rst_n)
        halt_mode |-> !irq_req);

    // R9
    halt_freeze_chk: assert property (@(posedge ref_clk) disable iff (!rst_n)
        halt_mode |=> ($stable(status_flag) && $stable(status_ie)));
endmodule

bind cm_clock_monitor cm_clock_monitor_chk #(.MIN_W(MIN_W)) u_chk (
    .ref_clk(ref_clk), .rst_n(rst_n), .en_q(en_q), .halt_mode(halt_mode),
    .irq_mask(irq_mask), .flag_clr_we(flag_clr_we), .fail_evt(fail_evt),
    .status_flag(status_flag), .status_ie(status_ie), .irq_req(irq_req),
    .sys_clk_out(sys_clk_out)
);

// File: tb/cm_clock_monitor_test.sv
// Bench for the clock monitor: sweeps main-clock half-periods, failure
// shapes, the interrupt gating, HALT/WAIT and the disabled passthrough.
module cm_clock_monitor_test;
    logic clk = 1'b0;
    logic rst_n, opt_enable, main_clk_in, safe_clk_in;
    logic halt_mode, wait_mode, irq_mask, ie_we, ie_wdata, flag_clr_we;
    logic sys_clk_out, status_flag, status_ie, irq_req, wait_wake;

    int checks = 0, errors = 0;
    int main_half = 3;
    logic main_stuck = 1'b0;
    int mcnt = 0, scnt = 0;
    localparam int SAFE_HALF = 40;
    localparam int WIN = 480;

    int rise_cnt = 0, run = 0, min_run = 1000;
    logic prev_s = 1'b0, seen_chg = 1'b0, mon_on = 1'b0;
    bit done = 0;

    always #10 clk = ~clk;

    cm_clock_monitor uut (
        .ref_clk(clk), .rst_n(rst_n), .opt_enable(opt_enable),
        .main_clk_in(main_clk_in), .safe_clk_in(safe_clk_in),
        .halt_mode(halt_mode), .wait_mode(wait_mode), .irq_mask(irq_mask),
        .ie_we(ie_we), .ie_wdata(ie_wdata), .flag_clr_we(flag_clr_we),
        .sys_clk_out(sys_clk_out), .status_flag(status_flag),
        .status_ie(status_ie), .irq_req(irq_req), .wait_wake(wait_wake)
    );

    // Main oscillator model: a square wave with a variable half-period, or a stuck level.
    always @(posedge clk) begin
        if (main_half == 0) main_clk_in <= main_stuck;
        else if (mcnt >= main_half - 1) begin
            mcnt <= 0;
            main_clk_in <= ~main_clk_in;
        end else mcnt <= mcnt + 1;
    end

    // Backup oscillator model: a slow, fixed square wave.
    always @(posedge clk) begin
        if (scnt >= SAFE_HALF - 1) begin
            scnt <= 0;
            safe_clk_in <= ~safe_clk_in;
        end else scnt <= scnt + 1;
    end

    // Output monitor: counts rising edges and tracks the narrowest level.
    always @(negedge clk) begin
        if (sys_clk_out !== prev_s) begin
            if (sys_clk_out) rise_cnt++;
            if (mon_on && seen_chg && run < min_run) min_run = run;
            seen_chg = 1'b1;
            run = 1;
        end else run++;
        prev_s = sys_clk_out;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic count_rises(input int n, output int r);
        int r0;
        r0 = rise_cnt;
        repeat (n) @(negedge clk);
        r = rise_cnt - r0;
    endtask

    task automatic chk_rate(input string req, input int exp);
        int n;
        count_rises(WIN, n);
        chk((n >= exp - 1) && (n <= exp + 1), req, n, exp);
    endtask

    task automatic settle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_clear();
        @(negedge clk) flag_clr_we = 1'b1;
        @(negedge clk) flag_clr_we = 1'b0;
    endtask

    task automatic write_ie(input logic v);
        @(negedge clk) begin ie_we = 1'b1; ie_wdata = v; end
        @(negedge clk) ie_we = 1'b0;
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int n;
        rst_n = 1'b0; opt_enable = 1'b1; safe_clk_in = 1'b0; main_clk_in = 1'b0;
        halt_mode = 1'b0; wait_mode = 1'b0; irq_mask = 1'b0;
        ie_we = 1'b0; ie_wdata = 1'b0; flag_clr_we = 1'b0;
        settle(5);
        // R11 reset state
        chk(status_flag == 0, "R11 flag", status_flag, 0);
        chk(status_ie == 0, "R11 ie", status_ie, 0);
        chk(irq_req == 0, "R11 irq", irq_req, 0);
        chk(sys_clk_out == 0, "R11 clk", sys_clk_out, 0);
        @(negedge clk) rst_n = 1'b1;
        mon_on = 1'b1;

        // R2: healthy main clock, half-periods at or above MIN_W pass at their rate
        for (int h = 2; h <= 5; h++) begin
            main_half = h;
            settle(300);
            chk_rate("R2 rate", WIN / (2 * h));
            chk(status_flag == 0, "R6 no spurious failover", status_flag, 0);
        end

        // R3: spikes of one reference cycle are removed entirely, so the backup clock takes over
        main_half = 1;
        settle(400);
        chk(status_flag == 1, "R3 spike failover flag", status_flag, 1);
        chk_rate("R3 backup rate", WIN / (2 * SAFE_HALF));
        chk(irq_req == 0, "R7 irq with ie=0", irq_req, 0);

        // R4: recovery returns to the main clock; R6 the flag stays set
        main_half = 3;
        settle(400);
        chk_rate("R4 main rate", WIN / 6);
        chk(status_flag == 1, "R6 sticky", status_flag, 1);
        pulse_clear();
        chk(status_flag == 0, "R6 clear", status_flag, 0);

        // R3: main clock stuck high, then R4 recovery
        main_half = 0; main_stuck = 1'b1;
        settle(400);
        chk(status_flag == 1, "R3 stuck-high flag", status_flag, 1);
        chk_rate("R3 stuck-high backup rate", WIN / (2 * SAFE_HALF));
        main_half = 2;
        settle(400);
        chk_rate("R4 recover rate", WIN / 4);
        chk(min_run >= 2, "R5 min level width", min_run, 2);

        // R7/R8: interrupt gating with main clock stuck low
        pulse_clear();
        write_ie(1'b1);
        chk(irq_req == 0, "R7 irq no flag", irq_req, 0);
        main_half = 0; main_stuck = 1'b0;
        settle(400);
        chk(irq_req == 1, "R7 irq raised", irq_req, 1);
        chk(wait_wake == 0, "R8 no wake outside wait", wait_wake, 0);
        @(negedge clk) wait_mode = 1'b1;
        @(negedge clk);
        chk(wait_wake == 1, "R8 wait wake", wait_wake, 1);
        @(negedge clk) irq_mask = 1'b1;
        @(negedge clk);
        chk(irq_req == 0, "R7 masked", irq_req, 0);
        chk(wait_wake == 0, "R8 masked wake", wait_wake, 0);
        @(negedge clk) begin irq_mask = 1'b0; wait_mode = 1'b0; end

        // R9: HALT freezes the block
        @(negedge clk) halt_mode = 1'b1;
        main_half = 2;
        count_rises(300, n);
        chk(n == 0, "R9 clock frozen", n, 0);
        chk(irq_req == 0, "R9 irq withheld", irq_req, 0);
        pulse_clear();
        write_ie(1'b0);
        chk(status_flag == 1, "R9 flag write ignored", status_flag, 1);
        chk(status_ie == 1, "R9 ie write ignored", status_ie, 1);

        // R10: configuration resumes after HALT
        @(negedge clk) halt_mode = 1'b0;
        @(negedge clk);
        chk(irq_req == 1, "R10 irq resumes", irq_req, 1);
        settle(400);
        chk_rate("R10 supervision resumes", WIN / 4);
        chk(min_run >= 2, "R5 min width after halt", min_run, 2);

        // R11: a reset restores the register reset value
        mon_on = 1'b0;
        @(negedge clk) begin rst_n = 1'b0; opt_enable = 1'b0; end
        settle(3);
        chk(status_flag == 0, "R11 flag after reset", status_flag, 0);
        chk(status_ie == 0, "R11 ie after reset", status_ie, 0);

        // R1: function disabled, raw main clock passes straight through
        @(negedge clk) rst_n = 1'b1;
        main_half = 1;
        n = 0;
        for (int i = 0; i < 400; i++) begin
            @(negedge clk);
            if (sys_clk_out !== main_clk_in) n++;
        end
        chk(n == 0, "R1 passthrough mismatches", n, 0);
        chk(status_flag == 0, "R1 no flag when disabled", status_flag, 0);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule